// File: doc/BRIEF.md
# Serial Port FIFO Flag and Interrupt Controller

This block keeps the status flags and interrupt requests of a serial port that has a transmit FIFO and a receive FIFO. The FIFOs, shift registers and baud logic sit outside it. They report to it through occupancy counts and single-cycle event strobes: a byte leaving the transmit FIFO, a byte entering the receive FIFO, receive errors, a break, and a DMA write into the transmit FIFO. Software reaches the block through a small register bus with two addresses. One address holds the control bits: transmit interrupt enable, receive interrupt enable and transmitter enable. The other holds the status flags.

Software clears a flag with a handshake. It first reads the status register while the flag shows 1, and then writes 0 to that bit. A write that has no qualifying read before it has no effect. The receive-full flag cannot be cleared while the receive FIFO still holds at least the trigger level. The block drives three requests: transmit data empty, receive data full, and receive error or break. It also drives a transmit start strobe.

Top module: `uart_fifo_irq_ctl`

## Requirements
- R1: The transmit-empty flag (status bit 0) is set one cycle after `tx_pop` is high with `tx_count` at or below `tx_trig`. A pop with the count above the trigger level does not set it.
- R2: The receive-full flag (status bit 1) is set one cycle after `rx_push` is high with `rx_count` at or above `rx_trig`. A push with the count below the trigger level does not set it.
- R3: `irq_txe` is high when the transmit interrupt enable (control bit 0, reset 0) is 1, the transmit-empty flag is 1, and `tx_count` is not above `tx_trig`. Clearing the enable removes the request and leaves the flag set.
- R4: The receive interrupt enable (control bit 1, reset 0) gates two requests. `irq_rxf` follows the receive-full flag. `irq_rxerr` follows the OR of the error and break flags.
- R5: A status write (`reg_addr`=1) of 0 clears a flag only when an earlier status read saw that flag at 1 and no write of any kind has happened since. Without such a read, the write leaves the flag unchanged.
- R6: A receive-full clear attempt made while `rx_count` is at or above `rx_trig` leaves the flag set. After the count drops below the trigger level, the read-then-write sequence clears it.
- R7: A `dma_wr` strobe clears the transmit-empty flag on the next edge, with no software read needed.
- R8: When a flag's set condition and a valid clear fall in the same cycle, the flag ends up set.
- R9: Receive error events set their own status bits: framing sets bit 2, parity sets bit 3, overrun sets bit 4. Any of them also sets the summary error bit 5. A break sets bit 6.
- R10: Status bit 7 reads 1 while the transmitter enable (control bit 2, reset 0) is 0. While the enable is 1, bit 7 reads 1 only when `tx_count` is 0.
- R11: `tx_start` is high in the same cycle as `tx_load` only while the transmitter enable is 1.
- R12: After reset, the control register reads 0x00, the status register reads 0x80, and all three requests are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register (combinational) |
| tx_count | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| tx_trig | input | 4 | Transmit trigger level |
| tx_pop | input | 1 | A byte moved from the transmit FIFO to the shifter |
| tx_load | input | 1 | A data write into the transmit FIFO |
| dma_wr | input | 1 | A DMA write into the transmit FIFO |
| rx_count | input | 5 | Receive FIFO occupancy, 0 to 16 |
| rx_trig | input | 4 | Receive trigger level |
| rx_push | input | 1 | A byte moved from the shifter into the receive FIFO |
| err_frame | input | 1 | Framing error event |
| err_parity | input | 1 | Parity error event |
| err_overrun | input | 1 | Overrun event |
| brk_det | input | 1 | Break detected |
| irq_txe | output | 1 | Transmit data empty request |
| irq_rxf | output | 1 | Receive data full request |
| irq_rxerr | output | 1 | Receive error or break request |
| tx_start | output | 1 | Start serial transmission |

## Verification
Flags, enables and markers are registered. A flag therefore shows in `reg_rdata` one edge after its event strobe or status write. The requests, the transmit start strobe and status bit 7 are combinational from those registers and the count inputs, so they follow a change in `tx_count`, `tx_load` or the control bits within the same cycle. The bench drives inputs 1 ns after a rising edge. It samples registered results after the next edge, and it samples combinational results before that edge while the stimulus is still held.

// File: rtl/uart_fifo_irq_ctl.sv
module uart_fifo_irq_ctl #(
  parameter int CW = 5,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [CW-1:0] tx_count,
  input  logic [TW-1:0] tx_trig,
  input  logic          tx_pop,
  input  logic          tx_load,
  input  logic          dma_wr,
  input  logic [CW-1:0] rx_count,
  input  logic [TW-1:0] rx_trig,
  input  logic          rx_push,
  input  logic          err_frame,
  input  logic          err_parity,
  input  logic          err_overrun,
  input  logic          brk_det,
  output logic          irq_txe,
  output logic          irq_rxf,
  output logic          irq_rxerr,
  output logic          tx_start
);
  localparam int NF = 7;
  localparam int F_TXE = 0;
  localparam int F_RXF = 1;
  localparam int F_SUM = 5;
  localparam int F_BRK = 6;

  logic [NF-1:0] flag_q, mark_q, set_v, clr_v;
  logic tie_q, rie_q, txen_q;

  wire [CW-1:0] txt = CW'(tx_trig);
  wire [CW-1:0] rxt = CW'(rx_trig);
  wire stat_rd = reg_rd & reg_addr;
  wire stat_wr = reg_wr & reg_addr;
  wire ctrl_wr = reg_wr & ~reg_addr;
  wire tx_low  = tx_count <= txt;
  wire rx_high = rx_count >= rxt;

  always_comb begin
    set_v        = '0;
    set_v[F_TXE] = tx_pop & tx_low;
    set_v[F_RXF] = rx_push & rx_high;
    set_v[2]     = err_frame;
    set_v[3]     = err_parity;
    set_v[4]     = err_overrun;
    set_v[F_SUM] = err_frame | err_parity | err_overrun;
    set_v[F_BRK] = brk_det;
  end

  always_comb begin
    clr_v = stat_wr ? (~reg_wdata[NF-1:0] & mark_q) : '0;
    if (rx_high) clr_v[F_RXF] = 1'b0;
    if (dma_wr)  clr_v[F_TXE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      mark_q <= '0;
      tie_q  <= 1'b0;
      rie_q  <= 1'b0;
      txen_q <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~clr_v) | set_v;
      if (reg_wr)       mark_q <= '0;
      else if (stat_rd) mark_q <= mark_q | flag_q;
      if (ctrl_wr) begin
        tie_q  <= reg_wdata[0];
        rie_q  <= reg_wdata[1];
        txen_q <= reg_wdata[2];
      end
    end
  end

  wire tdre = ~txen_q | (tx_count == '0);

  assign reg_rdata = reg_addr ? {tdre, flag_q} : {5'b0, txen_q, rie_q, tie_q};
  assign irq_txe   = tie_q & flag_q[F_TXE] & tx_low;
  assign irq_rxf   = rie_q & flag_q[F_RXF];
  assign irq_rxerr = rie_q & (|flag_q[F_BRK:2]);
  assign tx_start  = txen_q & tx_load;
endmodule

// File: rtl/uart_fifo_irq_ctl_chk.sv
module uart_fifo_irq_ctl_chk #(
  parameter int CW = 5,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_pop,
  input logic [CW-1:0] tx_count,
  input logic [TW-1:0] tx_trig,
  input logic          rx_push,
  input logic [CW-1:0] rx_count,
  input logic [TW-1:0] rx_trig,
  input logic          dma_wr,
  input logic          reg_wr,
  input logic          reg_addr,
  input logic [6:0]    flag_q,
  input logic [6:0]    mark_q,
  input logic          rie_q,
  input logic          irq_rxf,
  input logic          irq_rxerr
);
  a_r1_txe_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && tx_count <= CW'(tx_trig)) |=> flag_q[0]);

  a_r2_rxf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_count >= CW'(rx_trig)) |=> flag_q[1]);

  a_r4_rx_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !rie_q |-> (!irq_rxf && !irq_rxerr));

  a_r5_txe_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && !dma_wr && !(reg_wr && reg_addr && mark_q[0])) |=> flag_q[0]);

  for (genvar i = 1; i < 7; i++) begin : g_keep
    a_r5_flag_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !(reg_wr && reg_addr && mark_q[i])) |=> flag_q[i]);
  end

  a_r5_mark_drop: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (mark_q == '0));

  a_r6_rxf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[1] && rx_count >= CW'(rx_trig)) |=> flag_q[1]);
endmodule

bind uart_fifo_irq_ctl uart_fifo_irq_ctl_chk #(.CW(CW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_pop(tx_pop), .tx_count(tx_count), .tx_trig(tx_trig),
  .rx_push(rx_push), .rx_count(rx_count), .rx_trig(rx_trig), .dma_wr(dma_wr),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .flag_q(flag_q), .mark_q(mark_q),
  .rie_q(rie_q), .irq_rxf(irq_rxf), .irq_rxerr(irq_rxerr)
);

// File: tb/uart_fifo_irq_ctl_test.sv
module uart_fifo_irq_ctl_test;
  logic clk = 0, rst_n = 0;
  logic reg_rd = 0, reg_wr = 0, reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [4:0] tx_count = 0, rx_count = 0;
  logic [3:0] tx_trig = 4, rx_trig = 4;
  logic tx_pop = 0, tx_load = 0, dma_wr = 0, rx_push = 0;
  logic err_frame = 0, err_parity = 0, err_overrun = 0, brk_det = 0;
  logic irq_txe, irq_rxf, irq_rxerr, tx_start;
  int tests = 0, fails = 0;
  logic [7:0] d;

  uart_fifo_irq_ctl uut (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  task automatic rd(input logic a, output logic [7:0] v);
    reg_rd = 1; reg_addr = a; #1 v = reg_rdata; step(); reg_rd = 0;
  endtask

  task automatic wr(input logic a, input logic [7:0] v);
    reg_wr = 1; reg_addr = a; reg_wdata = v; step(); reg_wr = 0;
  endtask

  task automatic peek(output logic [7:0] v);
    reg_addr = 1; #1 v = reg_rdata;
  endtask

  task automatic pop(input logic [4:0] c);
    tx_count = c; tx_pop = 1; step(); tx_pop = 0;
  endtask

  task automatic push(input logic [4:0] c);
    rx_count = c; rx_push = 1; step(); rx_push = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; tx_count = 0; rx_count = 0; tx_trig = 4; rx_trig = 4;
    step(); step(); rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    rd(0, d); chk("R12 ctrl", d, 8'h00);
    rd(1, d); chk("R12 status", d, 8'h80);
    chk("R12 irqs", {5'b0, irq_txe, irq_rxf, irq_rxerr}, 8'h00);
  endtask

  task automatic t_tx_flag();
    do_reset(); wr(0, 8'h01);
    pop(6); peek(d); chk("R1 no set above trig", d & 8'h01, 8'h00);
    pop(4); peek(d); chk("R1 set at trig", d & 8'h01, 8'h01);
    chk("R3 irq on", irq_txe, 1);
    tx_count = 8; #1 chk("R3 masked above trig", irq_txe, 0);
    tx_count = 2; #1 chk("R3 back", irq_txe, 1);
    wr(0, 8'h00); chk("R3 tie off", irq_txe, 0);
    peek(d); chk("R3 flag kept", d & 8'h01, 8'h01);
  endtask

  task automatic t_clear();
    do_reset(); pop(1);
    wr(1, 8'h00); peek(d); chk("R5 no read no clear", d & 8'h01, 8'h01);
    rd(1, d); wr(1, 8'h00); peek(d); chk("R5 read-write clears", d & 8'h01, 8'h00);
    err_frame = 1; brk_det = 1; step(); err_frame = 0; brk_det = 0;
    rd(1, d); wr(0, 8'h00); wr(1, 8'h00); peek(d);
    chk("R5 mark dropped by write", d & 8'h7f, 8'h64);
  endtask

  task automatic t_dma_setwins();
    do_reset(); pop(0);
    dma_wr = 1; step(); dma_wr = 0;
    peek(d); chk("R7 dma clear", d & 8'h01, 8'h00);
    pop(2); rd(1, d);
    reg_wr = 1; reg_addr = 1; reg_wdata = 0; tx_count = 3; tx_pop = 1; step();
    reg_wr = 0; tx_pop = 0;
    peek(d); chk("R8 set wins", d & 8'h01, 8'h01);
  endtask

  task automatic t_rx();
    do_reset(); wr(0, 8'h02);
    push(3); peek(d); chk("R2 no set below trig", d & 8'h02, 8'h00);
    push(8); peek(d); chk("R2 set", d & 8'h02, 8'h02);
    chk("R4 irq_rxf", irq_rxf, 1);
    rd(1, d); wr(1, 8'h00); peek(d); chk("R6 blocked", d & 8'h02, 8'h02);
    rx_count = 2; rd(1, d); wr(1, 8'h00); peek(d); chk("R6 cleared", d & 8'h02, 8'h00);
    chk("R4 irq_rxf low", irq_rxf, 0);
  endtask

  task automatic t_err();
    do_reset();
    err_frame = 1; step(); err_frame = 0;
    peek(d); chk("R9 frame", d, 8'ha4);
    chk("R4 gated", irq_rxerr, 0);
    err_parity = 1; step(); err_parity = 0;
    err_overrun = 1; step(); err_overrun = 0;
    brk_det = 1; step(); brk_det = 0;
    peek(d); chk("R9 all", d, 8'hfc);
    wr(0, 8'h02); chk("R4 irq_rxerr", irq_rxerr, 1);
  endtask

  task automatic t_tdre_start();
    do_reset(); tx_count = 3; tx_load = 1;
    #1 chk("R11 disabled", tx_start, 0);
    peek(d); chk("R10 fixed 1", d & 8'h80, 8'h80);
    wr(0, 8'h04); #1 chk("R11 start", tx_start, 1);
    tx_load = 0; #1 chk("R11 idle", tx_start, 0);
    peek(d); chk("R10 not empty", d & 8'h80, 8'h00);
    tx_count = 0; peek(d); chk("R10 empty", d & 8'h80, 8'h80);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_tx_flag();
    t_clear();
    t_dma_setwins();
    t_rx();
    t_err();
    t_tdre_start();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule